// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block turns one instruction word of a 32-bit load/store instruction set into the addresses that instruction can use. Alongside the instruction it takes the value already read from the register named by the base field and the program counter, which has already been moved 4 bytes past the current instruction. It forms two candidate addresses. The displacement address is the base register plus a sign-extended 17-bit constant. The relative address is the PC plus a sign-extended 22-bit constant.

A base field of zero does not refer to register 0. It means that no base register is used, so the displacement becomes an absolute address. In that case a positive constant reaches 0x00000000..0x0000FFFF and a negative one reaches 0xFFFF0000..0xFFFFFFFF.

The block also decodes the six opcodes of the load/store family. It reports whether memory is read or written and which of the two addresses is used. For the two "load address" forms, it reports that the address itself is the register result. All results are captured into output registers on the clock edge that follows an input strobe.

Top module: `ea_unit`

## Requirements
- R1: While `rst` is high and on the first edge after it, every output is zero.
- R2: `out_valid` on an edge equals `in_valid` on the previous edge.
- R3: The fields are taken from fixed bit positions: opcode in bits 31..27, base field in bits 21..17, short constant in bits 16..0, long constant in bits 21..0. The long constant therefore includes the base field.
- R4: When the base field is zero, `disp_addr` is the short constant sign-extended to 32 bits, and `rb_value` has no effect.
- R5: When the base field is non-zero, `disp_addr` is `rb_value` plus the sign-extended short constant, modulo 2^32.
- R6: `rel_addr` is `pc_next` plus the long constant sign-extended to 32 bits, modulo 2^32.
- R7: Opcode 1 (load) sets `mem_read` and opcode 3 (store) sets `mem_write`. Both drive `eff_addr` from the displacement address.
- R8: Opcode 2 sets `mem_read` and opcode 4 sets `mem_write`. Both drive `eff_addr` from the relative address.
- R9: Opcode 5 sets `addr_is_result` with `eff_addr` equal to the displacement address. Opcode 6 sets it with `eff_addr` equal to the relative address.
- R10: For opcodes 0 and 7..31, `mem_read`, `mem_write`, `addr_is_result` and `sel_rel` are 0 and `eff_addr` is 0. `disp_addr` and `rel_addr` are still produced.
- R11: On an edge without `in_valid`, every output other than `out_valid` keeps its previous value.
- R12: `sel_rel` is 1 exactly for opcodes 2, 4 and 6, and 0 for every other opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: instruction and operands are present |
| instr | input | 32 | Instruction word |
| rb_value | input | 32 | Value of the register named by the base field |
| pc_next | input | 32 | PC already advanced past this instruction |
| out_valid | output | 1 | Registered outputs hold a new result |
| disp_addr | output | 32 | Displacement (or absolute) address |
| rel_addr | output | 32 | PC-relative address |
| eff_addr | output | 32 | Address chosen by the opcode, 0 outside the family |
| sel_rel | output | 1 | `eff_addr` comes from the relative path |
| mem_read | output | 1 | Instruction reads memory |
| mem_write | output | 1 | Instruction writes memory |
| addr_is_result | output | 1 | The address itself is the register result |

## Verification
The base field sits inside the long constant, so every instruction forms both addresses in the same cycle from overlapping bits. A base field of zero forces the absolute case on the displacement path. On the relative path, the same zero shrinks the long constant to a non-negative value below 2^17.

The bench sweeps all 32 opcodes against patterns that hit this overlap. These include a zero base field with a non-zero `rb_value`, a negative long constant with PC wrap-around, and base-plus-constant wrap. For each pattern it compares both addresses, the selected address and the flags with values it computes itself.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int OPC_W = 5;

  localparam logic [OPC_W-1:0] OPC_LOAD      = 5'd1;
  localparam logic [OPC_W-1:0] OPC_LOAD_REL  = 5'd2;
  localparam logic [OPC_W-1:0] OPC_STORE     = 5'd3;
  localparam logic [OPC_W-1:0] OPC_STORE_REL = 5'd4;
  localparam logic [OPC_W-1:0] OPC_ADDR      = 5'd5;
  localparam logic [OPC_W-1:0] OPC_ADDR_REL  = 5'd6;

  typedef struct packed {
    logic member;
    logic rd;
    logic wr;
    logic res;
    logic rel;
  } ea_ctrl_t;

  localparam ea_ctrl_t CTRL_NONE = '{member: 1'b0, rd: 1'b0, wr: 1'b0, res: 1'b0, rel: 1'b0};
endpackage

// File: rtl/ea_fields.sv
module ea_fields #(
  parameter int DATA_W  = 32,
  parameter int OP_W    = 5,
  parameter int REG_W   = 5,
  parameter int SHORT_W = 17,
  parameter int LONG_W  = 22
) (
  input  logic [DATA_W-1:0]  instr,
  output logic [OP_W-1:0]    op,
  output logic [REG_W-1:0]   base_idx,
  output logic [SHORT_W-1:0] short_k,
  output logic [LONG_W-1:0]  long_k
);
  localparam int OP_LSB = DATA_W - OP_W;
  localparam int RA_LSB = OP_LSB - REG_W;
  localparam int RB_LSB = RA_LSB - REG_W;

  always_comb begin
    op       = instr[DATA_W-1:OP_LSB];
    base_idx = instr[RA_LSB-1:RB_LSB];
    short_k  = instr[SHORT_W-1:0];
    long_k   = instr[LONG_W-1:0];
  end
endmodule

// File: rtl/ea_sext_add.sv
module ea_sext_add #(
  parameter int DATA_W = 32,
  parameter int K_W    = 17
) (
  input  logic [DATA_W-1:0] base,
  input  logic              base_en,
  input  logic [K_W-1:0]    k,
  output logic [DATA_W-1:0] sum
);
  localparam int EXT_W = DATA_W - K_W;

  logic [DATA_W-1:0] k_ext;
  logic [DATA_W-1:0] base_g;

  generate
    if (EXT_W > 0) begin : g_ext
      assign k_ext = {{EXT_W{k[K_W-1]}}, k};
    end else begin : g_noext
      assign k_ext = k[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    base_g = base_en ? base : '0;
    sum    = base_g + k_ext;
  end
endmodule

// File: rtl/ea_opdec.sv
module ea_opdec
  import ea_pkg::*;
(
  input  logic [OPC_W-1:0] op,
  output ea_ctrl_t         ctrl
);
  always_comb begin
    ctrl = CTRL_NONE;
    case (op)
      OPC_LOAD:      begin ctrl.member = 1'b1; ctrl.rd  = 1'b1; end
      OPC_LOAD_REL:  begin ctrl.member = 1'b1; ctrl.rd  = 1'b1; ctrl.rel = 1'b1; end
      OPC_STORE:     begin ctrl.member = 1'b1; ctrl.wr  = 1'b1; end
      OPC_STORE_REL: begin ctrl.member = 1'b1; ctrl.wr  = 1'b1; ctrl.rel = 1'b1; end
      OPC_ADDR:      begin ctrl.member = 1'b1; ctrl.res = 1'b1; end
      OPC_ADDR_REL:  begin ctrl.member = 1'b1; ctrl.res = 1'b1; ctrl.rel = 1'b1; end
      default:       ctrl = CTRL_NONE;
    endcase
  end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_W   = 5,
  parameter int SHORT_W = 17,
  parameter int LONG_W  = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] rb_value,
  input  logic [DATA_W-1:0] pc_next,
  output logic              out_valid,
  output logic [DATA_W-1:0] disp_addr,
  output logic [DATA_W-1:0] rel_addr,
  output logic [DATA_W-1:0] eff_addr,
  output logic              sel_rel,
  output logic              mem_read,
  output logic              mem_write,
  output logic              addr_is_result
);
  logic [OPC_W-1:0]   op;
  logic [REG_W-1:0]   base_idx;
  logic [SHORT_W-1:0] short_k;
  logic [LONG_W-1:0]  long_k;
  logic               base_en;
  logic [DATA_W-1:0]  disp_c;
  logic [DATA_W-1:0]  rel_c;
  logic [DATA_W-1:0]  eff_c;
  ea_ctrl_t           ctrl;

  ea_fields #(
    .DATA_W(DATA_W), .OP_W(OPC_W), .REG_W(REG_W),
    .SHORT_W(SHORT_W), .LONG_W(LONG_W)
  ) u_fields (
    .instr(instr), .op(op), .base_idx(base_idx),
    .short_k(short_k), .long_k(long_k)
  );

  assign base_en = (base_idx != '0);

  ea_sext_add #(.DATA_W(DATA_W), .K_W(SHORT_W)) u_disp (
    .base(rb_value), .base_en(base_en), .k(short_k), .sum(disp_c)
  );

  ea_sext_add #(.DATA_W(DATA_W), .K_W(LONG_W)) u_rel (
    .base(pc_next), .base_en(1'b1), .k(long_k), .sum(rel_c)
  );

  ea_opdec u_dec (.op(op), .ctrl(ctrl));

  always_comb begin
    if (!ctrl.member) eff_c = '0;
    else if (ctrl.rel) eff_c = rel_c;
    else eff_c = disp_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      disp_addr      <= '0;
      rel_addr       <= '0;
      eff_addr       <= '0;
      sel_rel        <= 1'b0;
      mem_read       <= 1'b0;
      mem_write      <= 1'b0;
      addr_is_result <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        disp_addr      <= disp_c;
        rel_addr       <= rel_c;
        eff_addr       <= eff_c;
        sel_rel        <= ctrl.rel;
        mem_read       <= ctrl.rd;
        mem_write      <= ctrl.wr;
        addr_is_result <= ctrl.res;
      end
    end
  end
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] instr,
  input logic        out_valid,
  input logic [31:0] disp_addr,
  input logic [31:0] rel_addr,
  input logic [31:0] eff_addr,
  input logic        sel_rel,
  input logic        mem_read,
  input logic        mem_write,
  input logic        addr_is_result
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_read, mem_write, addr_is_result})); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(eff_addr) && $stable(disp_addr) && $stable(rel_addr)
                   && $stable(mem_read) && $stable(mem_write)
                   && $stable(addr_is_result) && $stable(sel_rel))); // R11
  AST_ABS_DISP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[21:17] == 5'd0) |=>
      disp_addr == {{15{$past(instr[16])}}, $past(instr[16:0])}); // R4
  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (instr[31:27] == 5'd0 || instr[31:27] > 5'd6)) |=>
      (!mem_read && !mem_write && !addr_is_result && !sel_rel && eff_addr == 32'd0)); // R10
  AST_REL_PICK: assert property (@(posedge clk) disable iff (rst)
    (out_valid && sel_rel) |-> eff_addr == rel_addr); // R12
endmodule

bind ea_unit ea_unit_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
  .out_valid(out_valid), .disp_addr(disp_addr), .rel_addr(rel_addr),
  .eff_addr(eff_addr), .sel_rel(sel_rel), .mem_read(mem_read),
  .mem_write(mem_write), .addr_is_result(addr_is_result)
);

// File: tb/tb_ea_unit.sv
`timescale 1ns/1ps
module tb_ea_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] rb_value = '0;
  logic [31:0] pc_next = '0;
  logic        out_valid;
  logic [31:0] disp_addr, rel_addr, eff_addr;
  logic        sel_rel, mem_read, mem_write, addr_is_result;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  ea_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .rb_value(rb_value), .pc_next(pc_next), .out_valid(out_valid),
    .disp_addr(disp_addr), .rel_addr(rel_addr), .eff_addr(eff_addr),
    .sel_rel(sel_rel), .mem_read(mem_read), .mem_write(mem_write),
    .addr_is_result(addr_is_result)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string flag_req(input logic [4:0] op);
    if (op == 5'd1 || op == 5'd3) return "R7";
    if (op == 5'd2 || op == 5'd4) return "R8";
    if (op == 5'd5 || op == 5'd6) return "R9";
    return "R10";
  endfunction

  // Drive one strobed instruction, then check the result after the capturing edge
  task automatic run_one(input logic [31:0] ins, input logic [31:0] rbv, input logic [31:0] pc);
    logic [4:0]  op;
    logic [31:0] e_disp, e_rel, e_eff;
    bit          e_rd, e_wr, e_res, e_sr, member;
    string       fr;
    op     = ins[31:27];
    e_disp = ((ins[21:17] == 5'd0) ? 32'd0 : rbv) + {{15{ins[16]}}, ins[16:0]};
    e_rel  = pc + {{10{ins[21]}}, ins[21:0]};
    e_rd   = (op == 5'd1 || op == 5'd2);
    e_wr   = (op == 5'd3 || op == 5'd4);
    e_res  = (op == 5'd5 || op == 5'd6);
    e_sr   = (op == 5'd2 || op == 5'd4 || op == 5'd6);
    member = e_rd || e_wr || e_res;
    e_eff  = !member ? 32'd0 : (e_sr ? e_rel : e_disp);
    fr     = flag_req(op);
    @(negedge clk);
    instr = ins; rb_value = rbv; pc_next = pc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R2", "out_valid", 32'(out_valid), 32'd1);
    chk(disp_addr == e_disp, (ins[21:17] == 5'd0) ? "R4" : "R5", "disp_addr", disp_addr, e_disp);
    chk(rel_addr == e_rel, "R6", "rel_addr", rel_addr, e_rel);
    chk(eff_addr == e_eff, fr, "eff_addr", eff_addr, e_eff);
    chk({mem_read, mem_write, addr_is_result} == {e_rd, e_wr, e_res}, fr, "flags",
        32'({mem_read, mem_write, addr_is_result}), 32'({e_rd, e_wr, e_res}));
    chk(sel_rel == e_sr, "R12", "sel_rel", 32'(sel_rel), 32'(e_sr));
  endtask

  initial begin
    logic [31:0] keep_eff, keep_disp;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk({out_valid, mem_read, mem_write, addr_is_result, sel_rel} == 5'd0, "R1", "flags in reset",
        32'({out_valid, mem_read, mem_write, addr_is_result, sel_rel}), 32'd0);
    chk((disp_addr | rel_addr | eff_addr) == 32'd0, "R1", "addresses in reset",
        disp_addr | rel_addr | eff_addr, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "first edge after reset", 32'(out_valid), 32'd0);

    // R3 sweep: every opcode against patterns that stress field overlap
    for (int op = 0; op < 32; op++) begin
      // R4 base field zero: absolute, rb_value must not matter
      run_one({5'(op), 5'd9, 5'd0, 17'h0FFFF}, 32'hDEAD_BEEF, 32'h0000_1000);
      run_one({5'(op), 5'd9, 5'd0, 17'h10000}, 32'h1234_5678, 32'h0000_0004);
      run_one({5'(op), 5'd9, 5'd0, 17'h1FFFF}, 32'hFFFF_FFFF, 32'h8000_0000);
      // R5 base plus constant with wrap
      run_one({5'(op), 5'd1, 5'd3, 17'h0000B}, 32'h0000_0100, 32'h0000_2000);
      run_one({5'(op), 5'd2, 5'd31, 17'h00001}, 32'hFFFF_FFFF, 32'hFFFF_FFFC);
      // R6 negative long constant, PC wraps below zero
      run_one({5'(op), 5'd4, 5'd16, 17'h1FFD0}, 32'h7FFF_FFF0, 32'h0000_0010);
    end

    // R11 hold when no strobe
    run_one({5'd1, 5'd2, 5'd5, 17'h00020}, 32'h0000_4000, 32'h0000_0100);
    keep_eff  = eff_addr;
    keep_disp = disp_addr;
    @(negedge clk);
    instr = {5'd6, 5'd0, 5'd7, 17'h00FFF}; rb_value = 32'h5555_0000; pc_next = 32'h0BAD_0000;
    @(negedge clk);
    chk(out_valid == 1'b0, "R2", "out_valid idle", 32'(out_valid), 32'd0);
    chk(eff_addr == keep_eff, "R11", "eff_addr hold", eff_addr, keep_eff);
    chk(disp_addr == keep_disp, "R11", "disp_addr hold", disp_addr, keep_disp);
    chk(mem_read == 1'b1 && addr_is_result == 1'b0, "R11", "flags hold",
        32'({mem_read, addr_is_result}), 32'b10);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule